// File: doc/BRIEF.md
# Octant-Folded Phase-to-Exponential Generator

This block turns an unsigned phase word into the two Cartesian parts of a unit phasor: the real output carries the cosine of the angle and the imaginary output carries the sine. The phase word divides one full turn into equal steps. Code 0 is zero radians, and each step up adds one step's share of 2π, so the top code sits one step short of a full turn.

Only the first eighth of the circle is stored, as two small tables of magnitudes. The three top phase bits name the octant. The remaining bits give the position inside it. In odd octants that position is counted backwards from the octant's far edge. Each octant then picks whether the two table values change places and whether each one is negated. The result is registered, so a new phase can be presented every clock and its answer appears one clock later.

Top module: `cexp_octant_gen`

## Requirements
- R1: For every phase code p, one cycle after p is sampled, `re_o` equals round(2^AMP_W · cos(2π·p/2^PHASE_W)) and `im_o` equals round(2^AMP_W · sin(2π·p/2^PHASE_W)). Both are two's complement, and the rounding goes half away from zero. The defaults are PHASE_W=12, AMP_W=14 and OUT_W=16.
- R2: Each result is registered. A phase change reaches the outputs only at the next rising clock edge, and until that edge the previous result stays unchanged.
- R3: The reset is synchronous and active high. After a clock edge that samples `rst_i` high, both outputs read zero, whatever the phase.
- R4: The four axis phases 0, 1024, 2048 and 3072 give exactly (16384, 0), (0, 16384), (-16384, 0) and (0, -16384). Neither output ever leaves the range -16384 to +16384.
- R5: Phases on an octant boundary (multiples of 512) and their immediate neighbours give the exact values of R1. An odd octant at in-octant offset 0 uses the table's far end entry, which is the π/4 value 11585.
- R6: When the sampled phase has bit 11 clear, `im_o` is non-negative. When bits 11 and 10 of the sampled phase are equal, `re_o` is non-negative.
- R7: For any phase p, `re_o` for p equals `im_o` for the phase (1024 − p) mod 4096.
- R8: While the phase is held constant and reset stays low, both outputs stay constant from the second edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset; clears both outputs |
| phase_i | input | PHASE_W (12) | Unsigned phase, one full turn split into 2^PHASE_W steps |
| re_o | output | OUT_W (16) | Registered real part, cosine, two's complement, 1.0 = 2^AMP_W |
| im_o | output | OUT_W (16) | Registered imaginary part, sine, two's complement, 1.0 = 2^AMP_W |

## Verification
The bench builds the block at its default parameters: a 12-bit phase, 16-bit outputs and a full scale of 2^14. At these values the whole 4096-code circle can be swept one code per cycle, so every octant, every mirrored index and both ends of the stored table are compared against rounded floating-point cosine and sine. The full scale leaves one bit of headroom, so the ±1 points are checked exactly with no saturation. Seeded random phases, quadrant sign checks, the quarter-turn symmetry pairs, held phases and a reset in mid-run add to the sweep.

// File: rtl/cexp_pkg.sv
`timescale 1ns/1ps
package cexp_pkg;

    // Per-octant folding decision
    typedef struct packed {
        logic swap;    // exchange cosine and sine table values
        logic neg_re;  // negate the real result
        logic neg_im;  // negate the imaginary result
    } fold_ctl_t;

endpackage

// File: rtl/cexp_octant_decode.sv
`timescale 1ns/1ps
module cexp_octant_decode
    import cexp_pkg::*;
#(
    parameter int PHASE_W = 12
) (
    input  logic [PHASE_W-1:0] phase_i,
    output logic [PHASE_W-3:0] idx_o,   // table index, 0 .. 2^(PHASE_W-3)
    output fold_ctl_t          ctl_o
);
    localparam int FRAC_W = PHASE_W - 3;
    localparam logic [FRAC_W:0] SPAN = (FRAC_W+1)'(1) << FRAC_W;

    logic [2:0]        oct;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        oct  = phase_i[PHASE_W-1 -: 3];
        frac = phase_i[FRAC_W-1:0];
        // odd octants run toward the next multiple of pi/4, so count back from it
        if (oct[0]) idx_o = SPAN - {1'b0, frac};
        else        idx_o = {1'b0, frac};
        // octants 1,2,5,6 read the sine table for the real part
        ctl_o.swap   = oct[1] ^ oct[0];
        // cosine is negative in octants 2..5
        ctl_o.neg_re = oct[2] ^ oct[1];
        // sine is negative in octants 4..7
        ctl_o.neg_im = oct[2];
    end
endmodule

// File: rtl/cexp_eighth_table.sv
`timescale 1ns/1ps
module cexp_eighth_table #(
    parameter int FRAC_W = 9,
    parameter int AMP_W  = 14,
    parameter int OUT_W  = 16
) (
    input  logic [FRAC_W:0]   idx_i,
    output logic [OUT_W-1:0]  cos_mag_o,
    output logic [OUT_W-1:0]  sin_mag_o
);
    localparam int  ENTRIES = (1 << FRAC_W) + 1;
    localparam real QPI     = 0.78539816339744830962;
    localparam real STEP    = QPI / (2.0 ** FRAC_W);
    localparam real FULL    = 2.0 ** AMP_W;

    function automatic logic [OUT_W-1:0] to_mag(input real v);
        return OUT_W'($rtoi(v * FULL + 0.5));
    endfunction

    logic [OUT_W-1:0] cos_tab [ENTRIES];
    logic [OUT_W-1:0] sin_tab [ENTRIES];

    for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
        localparam real ANG = STEP * k;
        assign cos_tab[k] = to_mag($cos(ANG));
        assign sin_tab[k] = to_mag($sin(ANG));
    end

    assign cos_mag_o = cos_tab[idx_i];
    assign sin_mag_o = sin_tab[idx_i];
endmodule

// File: rtl/cexp_fold.sv
`timescale 1ns/1ps
module cexp_fold
    import cexp_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic [OUT_W-1:0]        cos_mag_i,
    input  logic [OUT_W-1:0]        sin_mag_i,
    input  fold_ctl_t               ctl_i,
    output logic signed [OUT_W-1:0] re_o,
    output logic signed [OUT_W-1:0] im_o
);
    logic [OUT_W-1:0] a;
    logic [OUT_W-1:0] b;

    always_comb begin
        a    = ctl_i.swap ? sin_mag_i : cos_mag_i;
        b    = ctl_i.swap ? cos_mag_i : sin_mag_i;
        re_o = ctl_i.neg_re ? -$signed(a) : $signed(a);
        im_o = ctl_i.neg_im ? -$signed(b) : $signed(b);
    end
endmodule

// File: rtl/cexp_octant_gen.sv
`timescale 1ns/1ps
module cexp_octant_gen
    import cexp_pkg::*;
#(
    parameter int PHASE_W = 12,
    parameter int OUT_W   = 16,
    parameter int AMP_W   = 14
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [PHASE_W-1:0]        phase_i,
    output logic signed [OUT_W-1:0]   re_o,
    output logic signed [OUT_W-1:0]   im_o
);
    localparam int FRAC_W = PHASE_W - 3;

    if (AMP_W > OUT_W - 2) begin : g_bad_amp
        $error("AMP_W must leave one headroom bit below the sign");
    end

    typedef struct packed {
        logic signed [OUT_W-1:0] re;
        logic signed [OUT_W-1:0] im;
    } out_t;

    logic [FRAC_W:0]         idx;
    fold_ctl_t               ctl;
    logic [OUT_W-1:0]        cos_mag;
    logic [OUT_W-1:0]        sin_mag;
    logic signed [OUT_W-1:0] fold_re;
    logic signed [OUT_W-1:0] fold_im;
    out_t                    state_d;
    out_t                    state_q;

    cexp_octant_decode #(.PHASE_W(PHASE_W)) decode_i (
        .phase_i (phase_i),
        .idx_o   (idx),
        .ctl_o   (ctl)
    );

    cexp_eighth_table #(.FRAC_W(FRAC_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) table_i (
        .idx_i     (idx),
        .cos_mag_o (cos_mag),
        .sin_mag_o (sin_mag)
    );

    cexp_fold #(.OUT_W(OUT_W)) fold_i (
        .cos_mag_i (cos_mag),
        .sin_mag_i (sin_mag),
        .ctl_i     (ctl),
        .re_o      (fold_re),
        .im_o      (fold_im)
    );

    always_comb begin
        state_d.re = fold_re;
        state_d.im = fold_im;
        if (rst_i) state_d = '0;
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign re_o = state_q.re;
    assign im_o = state_q.im;
endmodule

// File: rtl/cexp_octant_gen_chk.sv
`timescale 1ns/1ps
module cexp_octant_gen_chk #(
    parameter int PHASE_W = 12,
    parameter int OUT_W   = 16,
    parameter int AMP_W   = 14
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic [PHASE_W-1:0]      phase_i,
    input logic signed [OUT_W-1:0] re_o,
    input logic signed [OUT_W-1:0] im_o
);
    localparam logic signed [OUT_W-1:0] FULL = OUT_W'(1 << AMP_W);

    logic rst_prev_q = 1'b0;
    always_ff @(posedge clk_i) rst_prev_q <= rst_i;

    // R3: an edge that saw reset leaves both outputs at zero
    always_ff @(posedge clk_i) begin
        if (rst_prev_q) begin
            p_reset_zero_r3: assert (re_o == '0 && im_o == '0)
                else $error("outputs not cleared after reset");
        end
    end

    // R4: never beyond full scale
    p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (re_o <= FULL && re_o >= -FULL && im_o <= FULL && im_o >= -FULL));

    // R6: sine non-negative in the upper half turn
    p_im_sign_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(phase_i[PHASE_W-1])) |-> (im_o >= 0));

    // R6: cosine non-negative in the right half plane
    p_re_sign_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && ($past(phase_i[PHASE_W-1]) == $past(phase_i[PHASE_W-2])))
        |-> (re_o >= 0));

    // R4: phase 0 gives exactly (+1, 0)
    p_zero_phase_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(phase_i) == '0) |-> (re_o == FULL && im_o == '0));

    // R8: a held phase keeps the outputs steady
    p_hold_stable_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $stable(phase_i)) |=> ($stable(re_o) && $stable(im_o)));
endmodule

bind cexp_octant_gen cexp_octant_gen_chk #(
    .PHASE_W(PHASE_W), .OUT_W(OUT_W), .AMP_W(AMP_W)
) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .phase_i (phase_i),
    .re_o    (re_o),
    .im_o    (im_o)
);

// File: tb/cexp_octant_gen_tb_top.sv
`timescale 1ns/1ps
module cexp_octant_gen_tb_top;
    localparam int PHASE_W = 12;
    localparam int OUT_W   = 16;
    localparam int AMP_W   = 14;
    localparam int NCODES  = 1 << PHASE_W;
    localparam real TWO_PI = 6.28318530717958647692;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [PHASE_W-1:0]      phase = '0;
    logic signed [OUT_W-1:0] re;
    logic signed [OUT_W-1:0] im;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    cexp_octant_gen #(.PHASE_W(PHASE_W), .OUT_W(OUT_W), .AMP_W(AMP_W)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .phase_i (phase),
        .re_o    (re),
        .im_o    (im)
    );

    function automatic int ref_val(input int p, input bit want_im);
        real a = TWO_PI * p / (2.0 ** PHASE_W);
        real v = (want_im ? $sin(a) : $cos(a)) * (2.0 ** AMP_W);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    endfunction

    task automatic check(input string req, input int act, input int exp_v, input int p);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s phase=%0d actual=%0d expected=%0d", req, p, act, exp_v);
        end
    endtask

    // drive p at a falling edge, check at the next falling edge
    task automatic step(input int p, input string req);
        phase = PHASE_W'(p);
        @(negedge clk);
        check(req, int'(re), ref_val(p, 1'b0), p);
        check(req, int'(im), ref_val(p, 1'b1), p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R3: reset with a nonzero phase
        phase = 12'd700;
        repeat (3) @(negedge clk);
        check("R3", int'(re), 0, 700);
        check("R3", int'(im), 0, 700);
        rst = 1'b0;

        // R4: the four axis points
        step(0, "R4"); step(1024, "R4"); step(2048, "R4"); step(3072, "R4");
        check("R4", int'(re), 0, 3072);
        check("R4", int'(im), -16384, 3072);

        // R5: octant edges and their neighbours
        for (int k = 0; k < 8; k++) begin
            step(k * 512, "R5");
            step((k * 512 + 1) % NCODES, "R5");
            step((k * 512 + NCODES - 1) % NCODES, "R5");
        end
        step(512, "R5");
        check("R5", int'(re), 11585, 512);

        // R2: output holds until the edge
        step(0, "R2");
        phase = 12'd1024;
        #1;
        check("R2", int'(re), 16384, 1024);
        @(negedge clk);
        check("R2", int'(re), 0, 1024);
        check("R2", int'(im), 16384, 1024);

        // R1: every phase code
        for (int p = 0; p < NCODES; p++) step(p, "R1");

        // R1 and R6: seeded random phases with sign rule
        for (int n = 0; n < 3000; n++) begin
            int p = int'($urandom_range(NCODES - 1, 0));
            step(p, "R1");
            if (p < 2048)
                check("R6", int'(im >= 0), 1, p);
            if ((p >> 10) == 0 || (p >> 10) == 3)
                check("R6", int'(re >= 0), 1, p);
        end

        // R7: quarter-turn mirror pairs
        for (int n = 0; n < 40; n++) begin
            int p = int'($urandom_range(NCODES - 1, 0));
            int q = (1024 - p + NCODES) % NCODES;
            int re_p;
            step(p, "R7");
            re_p = int'(re);
            step(q, "R7");
            check("R7", int'(im), re_p, q);
        end

        // R8: held phase
        step(1777, "R8");
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            check("R8", int'(re), ref_val(1777, 1'b0), 1777);
            check("R8", int'(im), ref_val(1777, 1'b1), 1777);
        end

        // R3: reset in mid-run
        rst = 1'b1;
        phase = 12'd2500;
        @(negedge clk);
        check("R3", int'(re), 0, 2500);
        check("R3", int'(im), 0, 2500);
        rst = 1'b0;
        step(2500, "R3");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule